// File: doc/BRIEF.md
# UART Transmit Path with Byte Queue and Status Flags

This block is the sending half of a serial port. A host pushes bytes into a deep byte queue through a write strobe. A shift stage takes bytes from the head of the queue and sends each one as an asynchronous character on a single line. The shift stage advances only on cycles where an externally generated oversampling tick is high. A two-bit mode input sets each bit to 16, 8 or 4 ticks.

Two status flags describe the path. The queue-empty flag shows that no byte is waiting. The line-empty flag shows that, in addition, the last stop bit has finished on the line. A transmit interrupt supports flow control based on a level: the interrupt becomes pending when a byte leaves the queue and the remaining fill level is below a programmable trigger. The pending interrupt reaches the interrupt output only while the enable input is set. A status read clears it, and so does a host write that raises the level back to the trigger or above.

Top module: `uart_tx_fifo`

## Requirements
- R1: After reset the line is high, both empty flags are 1, and interrupt pending, interrupt and overflow are 0.
- R2: Each character is a low start bit, DW data bits least significant first, and a high stop bit. Every bit lasts 16, 8 or 4 tick cycles for bit_mode 2'b00, 2'b01 or 2'b10; 2'b11 also gives 16. Cycles without a tick do not advance the line.
- R3: When a byte is waiting as a stop bit ends, the next start bit begins on the tick that ends that stop bit. Consecutive start bits are therefore exactly 10 bit times apart.
- R4: Up to DEPTH bytes are held, and they are sent in the order they were written.
- R5: A write while DEPTH bytes are held is dropped and sets overflow, which stays 1 until reset.
- R6: hold_empty is 1 exactly when no byte is queued. It rises on the tick whose start bit takes the last byte, while line_empty is still 0.
- R7: shift_empty is 1 only when the queue is empty and no character is in progress. It rises on the tick that ends the last stop bit.
- R8: int_pend becomes 1 in the cycle after a byte leaves the queue and leaves a fill level below trig_lvl.
- R9: irq is registered: it equals int_pend ANDed with irq_en as sampled one clock earlier. While irq_en is 0, int_pend can be 1 and irq stays 0.
- R10: A status_rd pulse clears int_pend. A write that brings the level to trig_lvl or above also clears it. A setting event in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | DW | Byte to queue |
| trig_lvl | input | $clog2(DEPTH)+1 | Fill level below which the interrupt becomes pending |
| irq_en | input | 1 | Interrupt enable |
| status_rd | input | 1 | Interrupt status read pulse; clears pending |
| tick | input | 1 | Oversampling tick |
| bit_mode | input | 2 | Ticks per bit: 00=16, 01=8, 10=4, 11=16 |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Queue holds no byte |
| shift_empty | output | 1 | Queue empty and line idle |
| int_pend | output | 1 | Transmit interrupt pending |
| irq | output | 1 | Masked interrupt output |
| overflow | output | 1 | Sticky dropped-write indicator |

## Verification
The bench builds the block with DEPTH=8, which brings the full queue, the dropped ninth write and every trigger value within a handful of writes. A receive model in the bench counts ticks and decodes the line. It sweeps all 256 byte values through 4x mode in bursts of eight. Every mode, including the reserved code, is covered, along with a sparse tick spaced three clocks apart. Start-bit spacing and the edges of both empty flags are compared against tick counts computed in the bench.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;
  typedef enum logic [1:0] {
    OSR_X16 = 2'b00,
    OSR_X8  = 2'b01,
    OSR_X4  = 2'b10,
    OSR_RSV = 2'b11
  } osr_e;

  function automatic logic [4:0] ticks_per_bit(input osr_e m);
    case (m)
      OSR_X8:  return 5'd8;
      OSR_X4:  return 5'd4;
      default: return 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/txf_store.sv
module txf_store #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [AW:0]   level,
  output logic [AW:0]   level_nxt,
  output logic          pushed,
  output logic          popped,
  output logic          ovf
);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp, raddr;
  logic [DW-1:0] rd_q, byp_d;
  logic          byp_hit;

  assign pushed = push && (level != FULL_LVL);
  assign popped = pop && (level != '0);
  assign raddr  = popped ? rp + 1'b1 : rp;

  always_comb begin
    level_nxt = level;
    if (pushed && !popped) level_nxt = level + 1'b1;
    if (popped && !pushed) level_nxt = level - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (pushed) mem[wp] <= push_data;
    rd_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0; rp <= '0; level <= '0; ovf <= 1'b0;
      byp_hit <= 1'b0; byp_d <= '0;
    end else begin
      if (pushed) wp <= wp + 1'b1;
      rp      <= raddr;
      level   <= level_nxt;
      byp_hit <= pushed && (wp == raddr);
      byp_d   <= push_data;
      if (push && !pushed) ovf <= 1'b1;
    end
  end

  assign head = byp_hit ? byp_d : rd_q;

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (rst) level <= FULL_LVL);
  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && level == FULL_LVL) |=> (level == FULL_LVL));
  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst) ovf |=> ovf);
endmodule

// File: rtl/txf_shift.sv
module txf_shift
  import uart_txf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  osr_e          mode,
  input  logic          avail,
  input  logic [DW-1:0] head,
  output logic          take,
  output logic          busy,
  output logic          txd
);
  localparam int BW = $clog2(DW + 2);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW + 1);

  logic [DW:0]   shreg;
  logic [BW-1:0] bit_idx;
  logic [4:0]    tcnt, tpb_q;
  logic          last_tick, frame_end;

  assign last_tick = busy && tick && (tcnt == tpb_q - 5'd1);
  assign frame_end = last_tick && (bit_idx == LAST_BIT);
  assign take      = tick && avail && (!busy || frame_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; txd <= 1'b1; shreg <= '1;
      bit_idx <= '0; tcnt <= '0; tpb_q <= 5'd16;
    end else if (take) begin
      busy    <= 1'b1;
      txd     <= 1'b0;
      shreg   <= {1'b1, head};
      bit_idx <= '0;
      tcnt    <= '0;
      tpb_q   <= ticks_per_bit(mode);
    end else if (frame_end) begin
      busy <= 1'b0;
      txd  <= 1'b1;
    end else if (busy && tick) begin
      if (last_tick) begin
        tcnt    <= '0;
        bit_idx <= bit_idx + 1'b1;
        txd     <= shreg[0];
        shreg   <= {1'b1, shreg[DW:1]};
      end else begin
        tcnt <= tcnt + 5'd1;
      end
    end
  end

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> txd);
  // R3
  back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_end && avail) |=> (busy && !txd));
endmodule

// File: rtl/txf_irq.sv
module txf_irq #(
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pushed,
  input  logic          popped,
  input  logic [LW-1:0] level_nxt,
  input  logic [LW-1:0] trig,
  input  logic          irq_en,
  input  logic          status_rd,
  output logic          pending,
  output logic          irq
);
  logic set_ev, clr_ev, pend_nxt;

  assign set_ev   = popped && (level_nxt < trig);
  assign clr_ev   = status_rd || (pushed && (level_nxt >= trig));
  assign pend_nxt = set_ev ? 1'b1 : (clr_ev ? 1'b0 : pending);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      irq     <= 1'b0;
    end else begin
      pending <= pend_nxt;
      irq     <= pend_nxt & irq_en;
    end
  end

  // R8
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    (popped && level_nxt < trig) |=> pending);
  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(irq_en) && pending));
  // R10
  pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !popped) |=> !pending);
endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo
  import uart_txf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [DW-1:0]          wr_data,
  input  logic [$clog2(DEPTH):0] trig_lvl,
  input  logic                   irq_en,
  input  logic                   status_rd,
  input  logic                   tick,
  input  logic [1:0]             bit_mode,
  output logic                   txd,
  output logic                   hold_empty,
  output logic                   shift_empty,
  output logic                   int_pend,
  output logic                   irq,
  output logic                   overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [DW-1:0] head;
  logic [LW-1:0] level, level_nxt;
  logic          pushed, popped, take, busy;

  txf_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) store_i (
    .clk(clk), .rst(rst), .push(wr_en), .push_data(wr_data), .pop(take),
    .head(head), .level(level), .level_nxt(level_nxt),
    .pushed(pushed), .popped(popped), .ovf(overflow)
  );

  txf_shift #(.DW(DW)) shift_i (
    .clk(clk), .rst(rst), .tick(tick), .mode(osr_e'(bit_mode)),
    .avail(level != '0), .head(head), .take(take), .busy(busy), .txd(txd)
  );

  txf_irq #(.LW(LW)) irq_i (
    .clk(clk), .rst(rst), .pushed(pushed), .popped(popped),
    .level_nxt(level_nxt), .trig(trig_lvl), .irq_en(irq_en),
    .status_rd(status_rd), .pending(int_pend), .irq(irq)
  );

  assign hold_empty  = (level == '0);
  assign shift_empty = (level == '0) && !busy;
endmodule

// File: tb/uart_tx_fifo_tb_top.sv
module uart_tx_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int LW = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, irq_en = 1'b0, status_rd = 1'b0, tick = 1'b0;
  logic [7:0] wr_data = '0;
  logic [LW-1:0] trig_lvl = '0;
  logic [1:0] bit_mode = 2'b00;
  logic txd, hold_empty, shift_empty, int_pend, irq, overflow;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_tx_fifo #(.DEPTH(DEPTH), .DW(8)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .trig_lvl(trig_lvl),
    .irq_en(irq_en), .status_rd(status_rd), .tick(tick), .bit_mode(bit_mode),
    .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty),
    .int_pend(int_pend), .irq(irq), .overflow(overflow)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  int cur_tpb = 16, tick_div = 1, tdiv_cnt = 0;
  bit tick_on = 1'b0, tick_seen = 1'b0;
  int tick_total = 0, starts_seen = 0;
  bit rx_act = 1'b0;
  int rx_j = 0, rx_n = 0, ferr = 0;
  logic [7:0] rx_byte;
  logic [7:0] rx_q [64];
  int start_stamp [64];
  logic irq_at_start [64];
  logic he_prev = 1'b1, se_prev = 1'b1, se_at_he = 1'b0;
  int he_stamp = 0, se_stamp = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int tpb_of(input logic [1:0] m);
    case (m)
      2'b01: return 8;
      2'b10: return 4;
      default: return 16;
    endcase
  endfunction

  // tick generator and line receiver share one process
  always @(negedge clk) begin
    tick_seen = tick;
    if (!rst) begin
      if (tick_seen) tick_total++;
      if (!rx_act) begin
        if (tick_seen && txd == 1'b0) begin
          rx_act = 1'b1; rx_j = 0; starts_seen++;
          if (rx_n < 64) begin
            start_stamp[rx_n] = tick_total;
            irq_at_start[rx_n] = irq;
          end
        end
      end else if (tick_seen) begin
        rx_j++;
        if (rx_j % cur_tpb == cur_tpb / 2) begin
          if (rx_j / cur_tpb == 0) begin
            if (txd) ferr++;
          end else if (rx_j / cur_tpb <= 8) begin
            rx_byte[rx_j / cur_tpb - 1] = txd;
          end else begin
            if (!txd) ferr++;
            if (rx_n < 64) rx_q[rx_n] = rx_byte;
            rx_n++;
            rx_act = 1'b0;
          end
        end
      end
      if (hold_empty && !he_prev) begin he_stamp = tick_total; se_at_he = shift_empty; end
      if (shift_empty && !se_prev) se_stamp = tick_total;
      he_prev = hold_empty;
      se_prev = shift_empty;
    end
    if (tick_on) begin
      tick = (tdiv_cnt == 0);
      tdiv_cnt = (tdiv_cnt + 1) % tick_div;
    end else begin
      tick = 1'b0;
    end
  end

  task automatic wr(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (!(shift_empty && !rx_act) && guard < 20000) begin
      @(negedge clk); guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_starts(input int n);
    int guard = 0;
    while (starts_seen < n && guard < 20000) begin
      @(negedge clk); guard++;
    end
  endtask

  task automatic run_burst(input int n, input logic [1:0] m, input int tdiv,
                           input int base, input int step);
    bit_mode = m; cur_tpb = tpb_of(m); tick_div = tdiv; tdiv_cnt = 0;
    rx_n = 0; ferr = 0; tick_on = 1'b1;
    for (int i = 0; i < n; i++) wr(8'((base + i * step) & 255));
    wait_idle();
    chk("R4 frame count", rx_n, n);
    chk("R2 framing errors", ferr, 0);
    for (int i = 0; i < n; i++) begin
      chk("R2 R4 byte value", int'(rx_q[i]), (base + i * step) & 255);
      if (i > 0) chk("R3 start spacing", start_stamp[i] - start_stamp[i-1], 10 * cur_tpb);
    end
    chk("R7 line empty after last stop", se_stamp - start_stamp[n-1], 10 * cur_tpb);
    chk("R6 queue empty at last start", he_stamp, start_stamp[n-1]);
    chk("R6 line busy when queue empties", int'(se_at_he), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd", int'(txd), 1);
    chk("R1 hold_empty", int'(hold_empty), 1);
    chk("R1 shift_empty", int'(shift_empty), 1);
    chk("R1 int_pend", int'(int_pend), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 overflow", int'(overflow), 0);

    // R2 R3 modes, reserved code, sparse tick
    run_burst(8, 2'b00, 1, 8'h5A, 37);
    run_burst(8, 2'b01, 1, 8'h13, 91);
    run_burst(8, 2'b11, 1, 8'hC4, 29);
    run_burst(8, 2'b00, 3, 8'h81, 53);
    // R2 all byte values at 4 ticks per bit
    for (int c = 0; c < 32; c++) run_burst(8, 2'b10, 1, c * 8, 1);

    // R8 R9 R10 interrupt
    bit_mode = 2'b10; cur_tpb = 4; tick_div = 1; tick_on = 1'b0;
    repeat (2) @(negedge clk);
    trig_lvl = LW'(3); irq_en = 1'b1; rx_n = 0;
    wr(8'hA5);
    @(negedge clk);
    chk("R8 no pending before pop", int'(int_pend), 0);
    chk("R9 irq idle before pop", int'(irq), 0);
    tick_on = 1'b1;
    wait_starts(starts_seen + 1);
    tick_on = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 irq at pop below trigger", int'(irq_at_start[0]), 1);
    chk("R8 pending holds", int'(int_pend), 1);
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    chk("R10 status read clears pending", int'(int_pend), 0);
    chk("R10 status read clears irq", int'(irq), 0);
    irq_en = 1'b0;
    wr(8'h3C);
    chk("R10 write below trigger keeps clear", int'(int_pend), 0);
    tick_on = 1'b1;
    wait_starts(starts_seen + 1);
    tick_on = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 masked irq at pop", int'(irq_at_start[1]), 0);
    chk("R9 pending while masked", int'(int_pend), 1);
    chk("R9 irq low while masked", int'(irq), 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R9 irq one clock after enable", int'(irq), 1);
    wr(8'h01);
    chk("R10 level 1 keeps pending", int'(int_pend), 1);
    wr(8'h02);
    chk("R10 level 2 keeps pending", int'(int_pend), 1);
    wr(8'h03);
    chk("R10 level at trigger clears pending", int'(int_pend), 0);
    chk("R10 level at trigger clears irq", int'(irq), 0);
    tick_on = 1'b1;
    wait_idle();
    chk("R4 interrupt test frame count", rx_n, 5);
    chk("R8 pending after drain", int'(int_pend), 1);
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    trig_lvl = '0;

    // R5 R6 overflow with ticks stopped
    tick_on = 1'b0;
    repeat (2) @(negedge clk);
    rx_n = 0; ferr = 0;
    for (int i = 0; i < DEPTH; i++) wr(8'((i * 17 + 3) & 255));
    chk("R5 no overflow at capacity", int'(overflow), 0);
    chk("R6 hold_empty low with data", int'(hold_empty), 0);
    chk("R7 shift_empty low with data", int'(shift_empty), 0);
    chk("R2 line holds without ticks", int'(txd), 1);
    wr(8'hFF);
    chk("R5 overflow after full write", int'(overflow), 1);
    tick_on = 1'b1;
    wait_idle();
    chk("R5 dropped byte not sent", rx_n, DEPTH);
    for (int i = 0; i < DEPTH; i++)
      chk("R4 order after full", int'(rx_q[i]), (i * 17 + 3) & 255);
    chk("R5 overflow sticky", int'(overflow), 1);
    tick_on = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 R5 overflow cleared by reset", int'(overflow), 0);
    chk("R1 txd after reset", int'(txd), 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule